// File: doc/BRIEF.md
# Wavetable Sound Card Indirect Register Read Port

This block sits behind the host-visible index and data ports of a wavetable sound card. The host first writes an 8-bit register index. It then either writes the 16-bit data port or strobes a read of it. A read decodes the selected index and returns global readback values: the DMA control byte, the DMA address, the timer control byte, the reset register, the active voice count and the voice interrupt status. For indices 0x80 to 0x8D it returns fields of the currently selected voice. Indices above 0x8F fold onto their low alias before decoding.

Some reads change state. Reading the DMA control register acknowledges the DMA terminal-count interrupt. Reading the voice interrupt status register reports the lowest-numbered voice that has a wave or ramp interrupt pending, then pops both of that voice's pending bits. The block keeps the pending vectors, the terminal-count flag, the reset register and the active voice count. A write to the active count can be locked out while the DAC is running.

Top module: `snd_reg_port`

## Requirements
- R1: A read with an index above 0x8F decodes as the index with bit 7 cleared (0xCC reads as 0x4C, 0xC2 as 0x42, 0x91 as 0x11). Indices 0x80 to 0x8F are decoded unchanged. Writes always decode the raw index.
- R2: Reading 0x8E returns {3'b111, active_field[4:0]} in bits 15:8 and zero in bits 7:0. The field holds the voice count minus one and resets to 13.
- R3: Reading 0x41 returns in bits 15:8 the DMA control input with bit 6 replaced by the terminal-count flag, and zero in bits 7:0. The read clears the flag, which is also irq_status bit 7. A terminal-count event in the same cycle wins over the clear.
- R4: Reading 0x49 returns the same value as 0x41 and clears nothing.
- R5: Reading 0x4C returns the reset register with bit 2 replaced by the irq_enable input. The same byte appears in bits 15:8 and in bits 7:0.
- R6: Reading 0x8F returns in bits 15:8 the byte {no_wave_pending, no_ramp_pending, 1, voice[4:0]}. The voice is the lowest-numbered one with either bit pending, or 0 if none is pending. The read clears both of that voice's pending bits. irq_status bit 6 is the OR of all ramp pending bits and bit 5 is the OR of all wave pending bits.
- R7: With voice_valid low, 0x80 and 0x8D read 0x0300, 0x8C reads 0x0800, and the other voice indices read 0.
- R8: With voice_valid high, the voice reads return the following. 0x80 returns the wave control byte in bits 15:8 and 0x8D returns the ramp control byte in bits 15:8. 0x81 returns the frequency. 0x82 and 0x83 return the upper and lower halves of the start address. 0x84 and 0x85 return the halves of the end address. 0x8A and 0x8B return the halves of the current address. 0x8C returns the pan value in bits 11:8.
- R9: Reading 0x89 with a voice selected returns the integer part of the ramp volume (the volume shifted right by VOL_FRAC) shifted left by 4, truncated to 16 bits.
- R10: A data write with index 0x4C loads bits 15:8 into the reset register. A data write with index 0x0E loads bits 12:8 into the active field. When LOCK_ACTIVE is 1, that write is ignored while reset register bit 1 (DAC enable) is set.
- R11: A read of an index that decodes to no register returns the last value written to the data port (0 after reset).
- R12: The terminal-count flag and the voice pending bits are cleared only by a read strobe. A data write to index 0x41 or 0x8F leaves them unchanged.
- R13: rd_data is registered. It takes the decoded value on the clock edge that samples rd_stb and holds while rd_stb is low. It resets to 0.
- R14: Reading 0x42 returns the DMA address input. Reading 0x45 returns the timer control input in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Index register write strobe |
| idx_wdata | input | 8 | Index value |
| dat_we | input | 1 | Data port write strobe |
| dat_wdata | input | 16 | Data port write value |
| rd_stb | input | 1 | Data port read strobe |
| voice_valid | input | 1 | A voice is currently selected |
| v_wave_ctrl | input | 8 | Selected voice wave control byte |
| v_freq | input | 16 | Selected voice frequency |
| v_start | input | 32 | Selected voice start address |
| v_end | input | 32 | Selected voice end address |
| v_cur | input | 32 | Selected voice current address |
| v_vol | input | VOL_W | Selected voice ramp volume, VOL_FRAC fraction bits |
| v_pan | input | 4 | Selected voice pan |
| v_ramp_ctrl | input | 8 | Selected voice ramp control byte |
| dma_ctrl | input | 8 | DMA control byte |
| dma_addr | input | 16 | DMA address |
| timer_ctrl | input | 8 | Timer control byte |
| irq_enable | input | 1 | Interrupt enable state |
| tc_set | input | 1 | DMA terminal-count event |
| wave_set | input | NV | Per-voice wave interrupt events |
| ramp_set | input | NV | Per-voice ramp interrupt events |
| rd_data | output | 16 | Read data |
| irq_status | output | 8 | Global interrupt status: bit 7 terminal count, bit 6 any ramp, bit 5 any wave |

## Verification
The bench aims at the index fold boundary. Reads at 0xCC, 0xC2 and 0x91 must land on their low aliases, while 0x8E and 0x8F must not fold. A design that folds at the wrong threshold returns last-data or pops voice interrupts by mistake. The bench separates the acknowledging DMA read from the non-acknowledging one, and it performs data writes to the acknowledging indices. A design that clears on the wrong access loses the terminal-count flag early, which shows on irq_status and on the next readback. Voice status pops are checked in order across two voices with different wave and ramp combinations, which catches inverted "no pending" bits and a wrong priority. The active-count lock is exercised with the DAC bit set and then cleared, so that a design that always locks fails as well as one that never locks.

// File: rtl/snd_rd_pkg.sv
package snd_rd_pkg;

  // Read-side index codes (after folding)
  localparam logic [7:0] IX_DMA_CTRL  = 8'h41;
  localparam logic [7:0] IX_DMA_ADDR  = 8'h42;
  localparam logic [7:0] IX_TIMER     = 8'h45;
  localparam logic [7:0] IX_DMA_SAMP  = 8'h49;
  localparam logic [7:0] IX_RESET     = 8'h4C;
  localparam logic [7:0] IX_V_WAVE    = 8'h80;
  localparam logic [7:0] IX_V_FREQ    = 8'h81;
  localparam logic [7:0] IX_V_STARTH  = 8'h82;
  localparam logic [7:0] IX_V_STARTL  = 8'h83;
  localparam logic [7:0] IX_V_ENDH    = 8'h84;
  localparam logic [7:0] IX_V_ENDL    = 8'h85;
  localparam logic [7:0] IX_V_VOL     = 8'h89;
  localparam logic [7:0] IX_V_CURH    = 8'h8A;
  localparam logic [7:0] IX_V_CURL    = 8'h8B;
  localparam logic [7:0] IX_V_PAN     = 8'h8C;
  localparam logic [7:0] IX_V_RAMP    = 8'h8D;
  localparam logic [7:0] IX_ACTIVE_RD = 8'h8E;
  localparam logic [7:0] IX_IRQ_STAT  = 8'h8F;
  localparam logic [7:0] FOLD_LIMIT   = 8'h8F;

  // Write-side index codes (raw index)
  localparam logic [7:0] IX_ACTIVE_WR = 8'h0E;
  localparam logic [7:0] IX_RESET_WR  = 8'h4C;

  typedef struct packed {
    logic        valid;
    logic [7:0]  wave_ctrl;
    logic [15:0] freq;
    logic [31:0] start_a;
    logic [31:0] end_a;
    logic [31:0] cur_a;
    logic [15:0] vol_rb;
    logic [3:0]  pan;
    logic [7:0]  ramp_ctrl;
  } voice_view_t;

  function automatic logic [7:0] fold_index(input logic [7:0] raw);
    return (raw > FOLD_LIMIT) ? {1'b0, raw[6:0]} : raw;
  endfunction

  function automatic logic [15:0] vol_readback(input logic [31:0] vol, input int unsigned frac);
    logic [31:0] whole;
    whole = (vol >> frac) << 4;
    return whole[15:0];
  endfunction

  function automatic logic [7:0] dma_byte(input logic [7:0] ctrl, input logic tc);
    return {ctrl[7], tc, ctrl[5:0]};
  endfunction

  function automatic logic [7:0] reset_byte(input logic [7:0] r, input logic en);
    return {r[7:3], en, r[1:0]};
  endfunction

  function automatic logic [7:0] voice_stat_byte(input logic [4:0] v, input logic wave_p,
                                                 input logic ramp_p);
    return {~wave_p, ~ramp_p, 1'b1, v};
  endfunction

endpackage

// File: rtl/snd_host_regs.sv
module snd_host_regs
  import snd_rd_pkg::*;
#(
  parameter bit           LOCK_ACTIVE = 1'b1,
  parameter logic [4:0]   ACT_RST     = 5'd13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        idx_we,
  input  logic [7:0]  idx_wdata,
  input  logic        dat_we,
  input  logic [15:0] dat_wdata,
  output logic [7:0]  idx_q,
  output logic [15:0] last_data,
  output logic [7:0]  reset_q,
  output logic [4:0]  active_q,
  output logic        act_write_blocked
);

  logic act_write_hit;
  logic act_lock;

  assign act_write_hit = dat_we && (idx_q == IX_ACTIVE_WR);

  generate
    if (LOCK_ACTIVE) begin : g_lock
      assign act_lock = reset_q[1];
    end else begin : g_nolock
      assign act_lock = 1'b0;
    end
  endgenerate

  assign act_write_blocked = act_write_hit && act_lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      last_data <= '0;
      reset_q   <= '0;
      active_q  <= ACT_RST;
    end else begin
      if (idx_we) idx_q <= idx_wdata;
      if (dat_we) begin
        last_data <= dat_wdata;
        if (idx_q == IX_RESET_WR) reset_q <= dat_wdata[15:8];
        if (act_write_hit && !act_lock) active_q <= dat_wdata[12:8];
      end
    end
  end

endmodule

// File: rtl/snd_irq_track.sv
module snd_irq_track #(
  parameter int NV = 32,
  localparam int VW = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tc_set,
  input  logic [NV-1:0] wave_set,
  input  logic [NV-1:0] ramp_set,
  input  logic          ack_tc,
  input  logic          ack_voice,
  output logic          tc_flag,
  output logic [NV-1:0] wave_pend,
  output logic [NV-1:0] ramp_pend,
  output logic [VW-1:0] irq_voice,
  output logic          irq_voice_wave,
  output logic          irq_voice_ramp,
  output logic [7:0]    status
);

  // Lowest-numbered voice with anything pending wins
  always_comb begin
    irq_voice = '0;
    for (int i = NV - 1; i >= 0; i--) begin
      if (wave_pend[i] || ramp_pend[i]) irq_voice = VW'(i);
    end
  end

  assign irq_voice_wave = wave_pend[irq_voice];
  assign irq_voice_ramp = ramp_pend[irq_voice];

  generate
    for (genvar g = 0; g < NV; g++) begin : g_voice
      logic pop;
      assign pop = ack_voice && (irq_voice == VW'(g));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          wave_pend[g] <= 1'b0;
          ramp_pend[g] <= 1'b0;
        end else begin
          wave_pend[g] <= (wave_pend[g] && !pop) || wave_set[g];
          ramp_pend[g] <= (ramp_pend[g] && !pop) || ramp_set[g];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)      tc_flag <= 1'b0;
    else if (tc_set) tc_flag <= 1'b1;
    else if (ack_tc) tc_flag <= 1'b0;
  end

  assign status = {tc_flag, |ramp_pend, |wave_pend, 5'b0};

endmodule

// File: rtl/snd_read_mux.sv
module snd_read_mux
  import snd_rd_pkg::*;
(
  input  logic [7:0]  eff_idx,
  input  voice_view_t vv,
  input  logic [7:0]  dma_ctrl,
  input  logic        tc_flag,
  input  logic [15:0] dma_addr,
  input  logic [7:0]  timer_ctrl,
  input  logic [7:0]  reset_q,
  input  logic        irq_enable,
  input  logic [4:0]  active_q,
  input  logic [7:0]  stat_byte,
  input  logic [15:0] last_data,
  output logic [15:0] rd_value
);

  logic [7:0] rst_rb;
  assign rst_rb = reset_byte(reset_q, irq_enable);

  always_comb begin
    unique case (eff_idx)
      IX_DMA_CTRL,
      IX_DMA_SAMP:  rd_value = {dma_byte(dma_ctrl, tc_flag), 8'h00};
      IX_DMA_ADDR:  rd_value = dma_addr;
      IX_TIMER:     rd_value = {timer_ctrl, 8'h00};
      IX_RESET:     rd_value = {rst_rb, rst_rb};
      IX_V_WAVE:    rd_value = vv.valid ? {vv.wave_ctrl, 8'h00} : 16'h0300;
      IX_V_FREQ:    rd_value = vv.valid ? vv.freq : 16'h0000;
      IX_V_STARTH:  rd_value = vv.valid ? vv.start_a[31:16] : 16'h0000;
      IX_V_STARTL:  rd_value = vv.valid ? vv.start_a[15:0] : 16'h0000;
      IX_V_ENDH:    rd_value = vv.valid ? vv.end_a[31:16] : 16'h0000;
      IX_V_ENDL:    rd_value = vv.valid ? vv.end_a[15:0] : 16'h0000;
      IX_V_VOL:     rd_value = vv.valid ? vv.vol_rb : 16'h0000;
      IX_V_CURH:    rd_value = vv.valid ? vv.cur_a[31:16] : 16'h0000;
      IX_V_CURL:    rd_value = vv.valid ? vv.cur_a[15:0] : 16'h0000;
      IX_V_PAN:     rd_value = vv.valid ? {4'h0, vv.pan, 8'h00} : 16'h0800;
      IX_V_RAMP:    rd_value = vv.valid ? {vv.ramp_ctrl, 8'h00} : 16'h0300;
      IX_ACTIVE_RD: rd_value = {3'b111, active_q, 8'h00};
      IX_IRQ_STAT:  rd_value = {stat_byte, 8'h00};
      default:      rd_value = last_data;
    endcase
  end

endmodule

// File: rtl/snd_reg_port.sv
module snd_reg_port
  import snd_rd_pkg::*;
#(
  parameter int         NV          = 32,
  parameter int         VOL_W       = 20,
  parameter int         VOL_FRAC    = 8,
  parameter bit         LOCK_ACTIVE = 1'b1,
  parameter logic [4:0] ACT_RST     = 5'd13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_we,
  input  logic [7:0]       idx_wdata,
  input  logic             dat_we,
  input  logic [15:0]      dat_wdata,
  input  logic             rd_stb,
  input  logic             voice_valid,
  input  logic [7:0]       v_wave_ctrl,
  input  logic [15:0]      v_freq,
  input  logic [31:0]      v_start,
  input  logic [31:0]      v_end,
  input  logic [31:0]      v_cur,
  input  logic [VOL_W-1:0] v_vol,
  input  logic [3:0]       v_pan,
  input  logic [7:0]       v_ramp_ctrl,
  input  logic [7:0]       dma_ctrl,
  input  logic [15:0]      dma_addr,
  input  logic [7:0]       timer_ctrl,
  input  logic             irq_enable,
  input  logic             tc_set,
  input  logic [NV-1:0]    wave_set,
  input  logic [NV-1:0]    ramp_set,
  output logic [15:0]      rd_data,
  output logic [7:0]       irq_status
);

  localparam int VW = (NV > 1) ? $clog2(NV) : 1;

  logic [7:0]    idx_q;
  logic [15:0]   last_data;
  logic [7:0]    reset_q;
  logic [4:0]    active_q;
  logic          act_write_blocked;
  logic [7:0]    eff_idx;
  logic          ack_tc;
  logic          ack_voice;
  logic          tc_flag;
  logic [NV-1:0] wave_pend;
  logic [NV-1:0] ramp_pend;
  logic [VW-1:0] irq_voice;
  logic          irq_voice_wave;
  logic          irq_voice_ramp;
  logic [7:0]    stat_byte;
  logic [15:0]   rd_value;
  voice_view_t   vv;

  snd_host_regs #(
    .LOCK_ACTIVE(LOCK_ACTIVE),
    .ACT_RST    (ACT_RST)
  ) u_host (
    .clk              (clk),
    .rst_n            (rst_n),
    .idx_we           (idx_we),
    .idx_wdata        (idx_wdata),
    .dat_we           (dat_we),
    .dat_wdata        (dat_wdata),
    .idx_q            (idx_q),
    .last_data        (last_data),
    .reset_q          (reset_q),
    .active_q         (active_q),
    .act_write_blocked(act_write_blocked)
  );

  // Read decode: fold high indices onto their low alias
  assign eff_idx   = fold_index(idx_q);
  assign ack_tc    = rd_stb && (eff_idx == IX_DMA_CTRL);
  assign ack_voice = rd_stb && (eff_idx == IX_IRQ_STAT);

  snd_irq_track #(.NV(NV)) u_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .tc_set        (tc_set),
    .wave_set      (wave_set),
    .ramp_set      (ramp_set),
    .ack_tc        (ack_tc),
    .ack_voice     (ack_voice),
    .tc_flag       (tc_flag),
    .wave_pend     (wave_pend),
    .ramp_pend     (ramp_pend),
    .irq_voice     (irq_voice),
    .irq_voice_wave(irq_voice_wave),
    .irq_voice_ramp(irq_voice_ramp),
    .status        (irq_status)
  );

  assign stat_byte = voice_stat_byte(5'(irq_voice), irq_voice_wave, irq_voice_ramp);

  assign vv.valid     = voice_valid;
  assign vv.wave_ctrl = v_wave_ctrl;
  assign vv.freq      = v_freq;
  assign vv.start_a   = v_start;
  assign vv.end_a     = v_end;
  assign vv.cur_a     = v_cur;
  assign vv.vol_rb    = vol_readback(32'(v_vol), VOL_FRAC);
  assign vv.pan       = v_pan;
  assign vv.ramp_ctrl = v_ramp_ctrl;

  snd_read_mux u_mux (
    .eff_idx   (eff_idx),
    .vv        (vv),
    .dma_ctrl  (dma_ctrl),
    .tc_flag   (tc_flag),
    .dma_addr  (dma_addr),
    .timer_ctrl(timer_ctrl),
    .reset_q   (reset_q),
    .irq_enable(irq_enable),
    .active_q  (active_q),
    .stat_byte (stat_byte),
    .last_data (last_data),
    .rd_value  (rd_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= rd_value;
  end

endmodule

// File: rtl/snd_reg_port_chk.sv
module snd_reg_port_chk #(
  parameter int NV = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_stb,
  input logic [7:0]    eff_idx,
  input logic          tc_set,
  input logic [15:0]   rd_data,
  input logic [7:0]    irq_status,
  input logic [4:0]    active_q,
  input logic          act_write_blocked,
  input logic [NV-1:0] wave_pend,
  input logic [NV-1:0] ramp_pend,
  input logic [NV-1:0] wave_set,
  input logic [NV-1:0] ramp_set
);

  assert_tc_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && eff_idx == 8'h41 && !tc_set) |=> !irq_status[7]);

  assert_tc_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_status[7] && !(rd_stb && eff_idx == 8'h41)) |=> irq_status[7]);

  assert_count_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && eff_idx == 8'h8E) |=> (rd_data[15:13] == 3'b111 && rd_data[7:0] == 8'h00));

  assert_reset_mirror_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && eff_idx == 8'h4C) |=> (rd_data[15:8] == rd_data[7:0]));

  assert_rd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

  assert_active_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    act_write_blocked |=> $stable(active_q));

  assert_voice_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && eff_idx == 8'h8F && wave_set == '0 && ramp_set == '0) |=>
    ($countones({wave_pend, ramp_pend}) <= $past($countones({wave_pend, ramp_pend}))));

endmodule

bind snd_reg_port snd_reg_port_chk #(.NV(NV)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .rd_stb           (rd_stb),
  .eff_idx          (eff_idx),
  .tc_set           (tc_set),
  .rd_data          (rd_data),
  .irq_status       (irq_status),
  .active_q         (active_q),
  .act_write_blocked(act_write_blocked),
  .wave_pend        (wave_pend),
  .ramp_pend        (ramp_pend),
  .wave_set         (wave_set),
  .ramp_set         (ramp_set)
);

// File: tb/test_snd_reg_port.sv
module test_snd_reg_port;

  localparam time PERIOD = 10ns;
  localparam int  NV     = 32;
  localparam int  VOL_W  = 20;
  localparam int  NVEC   = 22;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             idx_we, dat_we, rd_stb;
  logic [7:0]       idx_wdata;
  logic [15:0]      dat_wdata;
  logic             voice_valid;
  logic [7:0]       v_wave_ctrl, v_ramp_ctrl, dma_ctrl, timer_ctrl;
  logic [15:0]      v_freq, dma_addr;
  logic [31:0]      v_start, v_end, v_cur;
  logic [VOL_W-1:0] v_vol;
  logic [3:0]       v_pan;
  logic             irq_enable, tc_set;
  logic [NV-1:0]    wave_set, ramp_set;
  logic [15:0]      rd_data;
  logic [7:0]       irq_status;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(PERIOD / 2) clk = ~clk;

  snd_reg_port #(.NV(NV), .VOL_W(VOL_W), .VOL_FRAC(8)) i_snd_reg_port (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wdata(idx_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .rd_stb(rd_stb),
    .voice_valid(voice_valid), .v_wave_ctrl(v_wave_ctrl), .v_freq(v_freq),
    .v_start(v_start), .v_end(v_end), .v_cur(v_cur), .v_vol(v_vol),
    .v_pan(v_pan), .v_ramp_ctrl(v_ramp_ctrl), .dma_ctrl(dma_ctrl),
    .dma_addr(dma_addr), .timer_ctrl(timer_ctrl), .irq_enable(irq_enable),
    .tc_set(tc_set), .wave_set(wave_set), .ramp_set(ramp_set),
    .rd_data(rd_data), .irq_status(irq_status)
  );

  // {requirement number, index, expected} for side-effect-free reads
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd8,  8'h80, 16'h5A00},  // R8 wave ctrl
    {8'd8,  8'h81, 16'h1234},  // R8 freq
    {8'd8,  8'h82, 16'hABCD},  // R8 start high
    {8'd8,  8'h83, 16'h0123},  // R8 start low
    {8'd8,  8'h84, 16'h0456},  // R8 end high
    {8'd8,  8'h85, 16'h789A},  // R8 end low
    {8'd9,  8'h89, 16'hA5C0},  // R9 volume integer << 4
    {8'd8,  8'h8A, 16'hCAFE},  // R8 current high
    {8'd8,  8'h8B, 16'hBEEF},  // R8 current low
    {8'd8,  8'h8C, 16'h0900},  // R8 pan
    {8'd8,  8'h8D, 16'h3300},  // R8 ramp ctrl
    {8'd2,  8'h8E, 16'hED00},  // R2 reset count field 13
    {8'd6,  8'h8F, 16'hE000},  // R6 nothing pending
    {8'd4,  8'h49, 16'h8500},  // R4 bit 6 replaced by flag 0
    {8'd3,  8'h41, 16'h8500},  // R3 no flag pending
    {8'd14, 8'h42, 16'h2468},  // R14 dma address
    {8'd14, 8'h45, 16'h1E00},  // R14 timer
    {8'd5,  8'h4C, 16'h0404},  // R5 mirrored reset byte
    {8'd1,  8'hCC, 16'h0404},  // R1 fold 0xCC -> 0x4C
    {8'd1,  8'hC2, 16'h2468},  // R1 fold 0xC2 -> 0x42
    {8'd1,  8'h91, 16'h0000},  // R1 fold 0x91 -> 0x11, unknown
    {8'd11, 8'hCE, 16'h0000}   // R11 unknown index after fold
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] i);
    @(negedge clk);
    idx_we = 1'b1; idx_wdata = i;
    @(negedge clk);
    idx_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] i, output logic [15:0] v);
    set_idx(i);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    v = rd_data;
  endtask

  task automatic wr(input logic [7:0] i, input logic [15:0] d);
    set_idx(i);
    dat_we = 1'b1; dat_wdata = d;
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] v, hold;
    rst_n = 1'b0; idx_we = 0; dat_we = 0; rd_stb = 0;
    idx_wdata = '0; dat_wdata = '0;
    voice_valid = 1'b1; v_wave_ctrl = 8'h5A; v_freq = 16'h1234;
    v_start = 32'hABCD_0123; v_end = 32'h0456_789A; v_cur = 32'hCAFE_BEEF;
    v_vol = 20'hA5C3E; v_pan = 4'h9; v_ramp_ctrl = 8'h33;
    dma_ctrl = 8'hC5; dma_addr = 16'h2468; timer_ctrl = 8'h1E;
    irq_enable = 1'b1; tc_set = 0; wave_set = '0; ramp_set = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    check("R13 reset rd_data", rd_data, 16'h0000);
    check("R6 reset irq_status", {8'h00, irq_status}, 16'h0000);

    for (int k = 0; k < NVEC; k++) begin
      rd(VEC[k][23:16], v);
      check($sformatf("R%0d idx 0x%02h", VEC[k][31:24], VEC[k][23:16]), v, VEC[k][15:0]);
    end

    // R11 last data written
    wr(8'h20, 16'h7777);
    rd(8'h20, v);
    check("R11 last data", v, 16'h7777);

    // R13 hold while no read strobe
    hold = rd_data;
    set_idx(8'h81);
    repeat (2) @(negedge clk);
    check("R13 hold", rd_data, hold);

    // R3 / R4 / R12 terminal count
    @(negedge clk); tc_set = 1'b1;
    @(negedge clk); tc_set = 1'b0;
    check("R3 flag set", {8'h00, irq_status}, 16'h0080);
    rd(8'h49, v);
    check("R4 sample read", v, 16'hC500);
    check("R4 no clear", {8'h00, irq_status}, 16'h0080);
    wr(8'h41, 16'h0101);
    check("R12 write 0x41 keeps flag", {8'h00, irq_status}, 16'h0080);
    rd(8'h41, v);
    check("R3 ack read", v, 16'hC500);
    check("R3 flag cleared", {8'h00, irq_status}, 16'h0000);
    rd(8'h49, v);
    check("R3 after ack", v, 16'h8500);

    // R6 / R12 voice status pops
    @(negedge clk); wave_set = 32'h0000_0008; ramp_set = 32'h0000_0088;
    @(negedge clk); wave_set = '0; ramp_set = '0;
    check("R6 status both", {8'h00, irq_status}, 16'h0060);
    wr(8'h8F, 16'h0202);
    check("R12 write 0x8F keeps pending", {8'h00, irq_status}, 16'h0060);
    rd(8'h8F, v);
    check("R6 voice 3", v, 16'h2300);
    check("R6 status ramp left", {8'h00, irq_status}, 16'h0040);
    rd(8'h8F, v);
    check("R6 voice 7", v, 16'hA700);
    check("R6 status empty", {8'h00, irq_status}, 16'h0000);

    // R7 no voice selected
    voice_valid = 1'b0;
    rd(8'h80, v); check("R7 wave default", v, 16'h0300);
    rd(8'h8D, v); check("R7 ramp default", v, 16'h0300);
    rd(8'h8C, v); check("R7 pan default", v, 16'h0800);
    rd(8'h81, v); check("R7 freq default", v, 16'h0000);
    rd(8'h89, v); check("R7 vol default", v, 16'h0000);
    voice_valid = 1'b1;

    // R10 active count lock
    wr(8'h0E, 16'h1F00);
    rd(8'h8E, v); check("R10 unlocked write", v, 16'hFF00);
    wr(8'h4C, 16'h0200);
    rd(8'h4C, v); check("R5 reset reg dac", v, 16'h0606);
    wr(8'h0E, 16'h0500);
    rd(8'h8E, v); check("R10 locked write ignored", v, 16'hFF00);
    wr(8'h4C, 16'h0000);
    wr(8'h0E, 16'h0500);
    rd(8'h8E, v); check("R10 write after unlock", v, 16'hE500);

    // R5 / R1 bit 2 from irq_enable via alias
    wr(8'h4C, 16'h0700);
    irq_enable = 1'b0;
    rd(8'hCC, v); check("R5 alias irq_enable low", v, 16'h0303);

    finish_run();
  end

endmodule